// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Parallel Test Mode

This block is the device-side front end of a dynamic memory's timing generator. It samples the active-low row strobe, column strobe, write enable and output enable on a local clock. From the order in which the strobes fall, it decides what kind of memory cycle is running. It then issues one-cycle command pulses toward an abstract array model: row activate, column read, column write and refresh. It also presents the row and column addresses that go with those pulses.

The block owns the internal refresh row counter. A column-before-row cycle refreshes the row that the counter holds, and the counter steps once that cycle ends. A cycle in which the row strobe opens and closes with no column strobe refreshes the row applied at the pins.

A latched parallel-test flag is set by a cycle in which both the column strobe and write enable are asserted before the row strobe. Any refresh cycle of either kind clears it. While the flag is set, each data output reports whether the two internal bits behind it agree. The top column bit, which normally picks one of the two, is ignored in that case.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After synchronous reset `cyc_code` is 0 (idle), `test_mode` is 0, `dq_oe` is 0 and the refresh row counter is 0, so the first column-before-row refresh uses row 0.
- R2: When the row strobe falls while the column strobe has not already been low on the previous sample, the block pulses `act_strobe` once, latches `row_in` into `row_addr`, and sets `cyc_code` to 7 (row open). Strobes that fall on the same sample count as row first.
- R3: The first column strobe fall in an open row, and each later fall (page mode), with write enable high, sets `cyc_code` to 1 (read), latches `col_in` into `col_addr` and pulses `rd_strobe`.
- R4: A column strobe fall with write enable already low sets `cyc_code` to 2 (early write) and pulses `wr_strobe`. `dq_oe` stays 0 for the whole cycle, even with output enable low.
- R5: Write enable falling while the column strobe is low in a read sets `cyc_code` to 3 (read-modify-write) and pulses `wr_strobe`.
- R6: The row strobe rising after a row opened with no column strobe fall sets `cyc_code` to 4 (row-only refresh). It pulses `ref_strobe` with `row_addr` equal to the latched external row, and it clears `test_mode`.
- R7: The row strobe falling while the column strobe was already low and write enable is high sets `cyc_code` to 5. This includes a hidden refresh, where the column strobe is held low from a previous read. The block pulses `ref_strobe` with `row_addr` equal to the counter and clears `test_mode`. The counter advances by one, modulo 2^ROW_W, when the row strobe rises.
- R8: The row strobe falling while both the column strobe and write enable were already low sets `cyc_code` to 6 and sets `test_mode`, with no refresh pulse. `test_mode` stays set across later cycles until an R6 or R7 cycle.
- R9: `dq_oe` is 1 only while `cyc_code` is 1 or 3 and the column strobe and output enable are both low.
- R10: With `test_mode` clear, `dq_out[i]` equals `array_rd[DQ_W+i]` when the top bit of `col_addr` is 1, and `array_rd[i]` otherwise. With `test_mode` set, `dq_out[i]` is 1 exactly when `array_rd[i]` equals `array_rd[DQ_W+i]`, whatever the top column bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| row_in | input | ROW_W | External row address |
| col_in | input | COL_W | External column address |
| array_rd | input | 2*DQ_W | Two internal bits per output from the array model |
| cyc_code | output | 3 | Current cycle classification |
| act_strobe | output | 1 | Row activate pulse |
| rd_strobe | output | 1 | Column read pulse |
| wr_strobe | output | 1 | Column write pulse |
| ref_strobe | output | 1 | Refresh pulse for `row_addr` |
| row_addr | output | ROW_W | Row for activate or refresh |
| col_addr | output | COL_W | Latched column |
| test_mode | output | 1 | Latched parallel-test flag |
| dq_oe | output | 1 | Data output drive enable |
| dq_out | output | DQ_W | Data output value |

## Verification
The bench builds the block with ROW_W=4, COL_W=4, DQ_W=2 and two synchronizer stages. With a 4-bit counter, eighteen back-to-back column-before-row refreshes carry the counter through its wrap from 15 to 0. With two outputs, every 4-bit combination of internal bits can be swept against both values of the ignored column bit. The small row field also lets every row be opened and read with a column derived from it. The bench also checks that strobes falling on the same sample open a normal access.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_READ    = 3'd1,
        CYC_EWRITE  = 3'd2,
        CYC_RMW     = 3'd3,
        CYC_ROR     = 3'd4,
        CYC_CBR     = 3'd5,
        CYC_TENTRY  = 3'd6,
        CYC_ROWOPEN = 3'd7
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_CBR,
        ST_TEST
    } st_e;

    // Strobes in active-high form after synchronization
    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobes_t;

    localparam int STROBE_W = $bits(strobes_t);

    function automatic logic drives_data(cyc_e c);
        return (c == CYC_READ) || (c == CYC_RMW);
    endfunction

endpackage

// File: rtl/dcd_sync.sv
module dcd_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dcd_refresh_ctr.sv
module dcd_refresh_ctr #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)      value <= '0;
        else if (adv) value <= value + 1'b1;
    end
endmodule

// File: rtl/dcd_dq_path.sv
module dcd_dq_path #(
    parameter int DQ_W = 8
) (
    input  logic [2*DQ_W-1:0] array_rd,
    input  logic              sel_hi,
    input  logic              test_mode,
    output logic [DQ_W-1:0]   dq_out
);
    for (genvar i = 0; i < DQ_W; i++) begin : g_bit
        logic lo_bit, hi_bit;
        assign lo_bit    = array_rd[i];
        assign hi_bit    = array_rd[DQ_W+i];
        assign dq_out[i] = test_mode ? ~(lo_bit ^ hi_bit)
                                     : (sel_hi ? hi_bit : lo_bit);
    end
endmodule

// File: rtl/dcd_classifier.sv
module dcd_classifier
    import dcd_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  strobes_t         smp,
    input  logic [ROW_W-1:0] row_in,
    input  logic [COL_W-1:0] col_in,
    input  logic [ROW_W-1:0] ctr_val,
    output cyc_e             code,
    output logic             act_strobe,
    output logic             rd_strobe,
    output logic             wr_strobe,
    output logic             ref_strobe,
    output logic             ctr_adv,
    output logic             test_mode,
    output logic [ROW_W-1:0] row_addr,
    output logic [COL_W-1:0] col_addr,
    output logic             dq_oe
);
    strobes_t prv;
    st_e      state;

    logic ras_fall, ras_rise, we_fall, col_evt;

    assign ras_fall = smp.ras & ~prv.ras;
    assign ras_rise = ~smp.ras & prv.ras;
    assign we_fall  = smp.we & ~prv.we;
    // First column in an open row is level-triggered so that a column
    // strobe that fell on the same sample as the row strobe is not lost.
    assign col_evt  = smp.cas & ((state == ST_ROW) | ((state == ST_COL) & ~prv.cas));

    always_ff @(posedge clk) begin
        if (rst) begin
            prv        <= '0;
            state      <= ST_IDLE;
            code       <= CYC_IDLE;
            act_strobe <= 1'b0;
            rd_strobe  <= 1'b0;
            wr_strobe  <= 1'b0;
            ref_strobe <= 1'b0;
            ctr_adv    <= 1'b0;
            test_mode  <= 1'b0;
            row_addr   <= '0;
            col_addr   <= '0;
        end else begin
            prv        <= smp;
            act_strobe <= 1'b0;
            rd_strobe  <= 1'b0;
            wr_strobe  <= 1'b0;
            ref_strobe <= 1'b0;
            ctr_adv    <= 1'b0;
            if (ras_fall) begin
                if (prv.cas && smp.cas) begin
                    if (smp.we) begin
                        state     <= ST_TEST;
                        code      <= CYC_TENTRY;
                        test_mode <= 1'b1;
                    end else begin
                        state      <= ST_CBR;
                        code       <= CYC_CBR;
                        row_addr   <= ctr_val;
                        ref_strobe <= 1'b1;
                        test_mode  <= 1'b0;
                    end
                end else begin
                    state      <= ST_ROW;
                    code       <= CYC_ROWOPEN;
                    row_addr   <= row_in;
                    act_strobe <= 1'b1;
                end
            end else if (ras_rise) begin
                case (state)
                    ST_ROW: begin
                        code       <= CYC_ROR;
                        ref_strobe <= 1'b1;
                        test_mode  <= 1'b0;
                    end
                    ST_CBR:  ctr_adv <= 1'b1;
                    default: ;
                endcase
                state <= ST_IDLE;
            end else if (col_evt) begin
                state    <= ST_COL;
                col_addr <= col_in;
                if (smp.we) begin
                    code      <= CYC_EWRITE;
                    wr_strobe <= 1'b1;
                end else begin
                    code      <= CYC_READ;
                    rd_strobe <= 1'b1;
                end
            end else if (state == ST_COL && we_fall && smp.cas && code == CYC_READ) begin
                code      <= CYC_RMW;
                wr_strobe <= 1'b1;
            end
        end
    end

    assign dq_oe = drives_data(code) & smp.cas & smp.oe;
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
    import dcd_pkg::*;
#(
    parameter int ROW_W       = 11,
    parameter int COL_W       = 10,
    parameter int DQ_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic [2*DQ_W-1:0] array_rd,
    output logic [2:0]        cyc_code,
    output logic              act_strobe,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              ref_strobe,
    output logic [ROW_W-1:0]  row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic              test_mode,
    output logic              dq_oe,
    output logic [DQ_W-1:0]   dq_out
);
    strobes_t raw_act, smp;
    cyc_e     code;
    logic     ctr_adv;
    logic [ROW_W-1:0] ref_ctr_q;

    assign raw_act = '{ras: ~ras_n, cas: ~cas_n, we: ~we_n, oe: ~oe_n};

    dcd_sync #(
        .W       (STROBE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_act),
        .q   (smp)
    );

    dcd_refresh_ctr #(.ROW_W(ROW_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .adv   (ctr_adv),
        .value (ref_ctr_q)
    );

    dcd_classifier #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cls (
        .clk        (clk),
        .rst        (rst),
        .smp        (smp),
        .row_in     (row_in),
        .col_in     (col_in),
        .ctr_val    (ref_ctr_q),
        .code       (code),
        .act_strobe (act_strobe),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .ref_strobe (ref_strobe),
        .ctr_adv    (ctr_adv),
        .test_mode  (test_mode),
        .row_addr   (row_addr),
        .col_addr   (col_addr),
        .dq_oe      (dq_oe)
    );

    dcd_dq_path #(.DQ_W(DQ_W)) u_dq (
        .array_rd  (array_rd),
        .sel_hi    (col_addr[COL_W-1]),
        .test_mode (test_mode),
        .dq_out    (dq_out)
    );

    assign cyc_code = code;
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
    import dcd_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       cyc_code,
    input logic             act_strobe,
    input logic             rd_strobe,
    input logic             wr_strobe,
    input logic             ref_strobe,
    input logic             test_mode,
    input logic             dq_oe,
    input logic [ROW_W-1:0] ref_ctr
);
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (cyc_code == CYC_READ || cyc_code == CYC_RMW));           // R9

    AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(test_mode) |-> (cyc_code == CYC_TENTRY));                     // R8

    AST_TEST_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(test_mode) |-> (cyc_code == CYC_ROR || cyc_code == CYC_CBR)); // R7

    AST_REF_KIND: assert property (@(posedge clk) disable iff (rst)
        ref_strobe |-> (cyc_code == CYC_ROR || cyc_code == CYC_CBR));       // R6

    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act_strobe, rd_strobe, wr_strobe, ref_strobe}));          // R2

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_ctr) |-> (ref_ctr == ROW_W'($past(ref_ctr) + 1'b1)));  // R7
endmodule

bind dram_cycle_decoder dcd_checker #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cyc_code   (cyc_code),
    .act_strobe (act_strobe),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .ref_strobe (ref_strobe),
    .test_mode  (test_mode),
    .dq_oe      (dq_oe),
    .ref_ctr    (ref_ctr_q)
);

// File: tb/dram_cycle_decoder_tb.sv
module dram_cycle_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 4;
    localparam int COL_W = 4;
    localparam int DQ_W  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ROW_W-1:0]  row_in = '0;
    logic [COL_W-1:0]  col_in = '0;
    logic [2*DQ_W-1:0] array_rd = '0;
    logic [2:0]        cyc_code;
    logic act_strobe, rd_strobe, wr_strobe, ref_strobe, test_mode, dq_oe;
    logic [ROW_W-1:0] row_addr;
    logic [COL_W-1:0] col_addr;
    logic [DQ_W-1:0]  dq_out;

    int n_chk = 0, n_fail = 0;
    int n_act = 0, n_rd = 0, n_wr = 0, n_ref = 0;
    logic [ROW_W-1:0] last_ref_row = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .row_in(row_in), .col_in(col_in), .array_rd(array_rd), .cyc_code(cyc_code),
        .act_strobe(act_strobe), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .ref_strobe(ref_strobe), .row_addr(row_addr), .col_addr(col_addr),
        .test_mode(test_mode), .dq_oe(dq_oe), .dq_out(dq_out)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (act_strobe) n_act <= n_act + 1;
            if (rd_strobe)  n_rd  <= n_rd + 1;
            if (wr_strobe)  n_wr  <= n_wr + 1;
            if (ref_strobe) begin
                n_ref        <= n_ref + 1;
                last_ref_row <= row_addr;
            end
        end
    end

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic release_all();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        settle();
    endtask

    task automatic cbr_cycle(int exp_row, int exp_code);
        int r0;
        r0 = n_ref;
        cas_n = 1'b0; settle();
        ras_n = 1'b0; settle();
        chk("R7 cbr code", cyc_code, exp_code);
        chk("R7 cbr ref pulse", n_ref, r0 + 1);
        chk("R7 cbr row", last_ref_row, exp_row);
        ras_n = 1'b1; settle();
        cas_n = 1'b1; settle();
    endtask

    task automatic enter_test();
        int r0;
        r0 = n_ref;
        cas_n = 1'b0; we_n = 1'b0; settle();
        ras_n = 1'b0; settle();
        chk("R8 entry code", cyc_code, 6);
        chk("R8 test set", test_mode, 1);
        chk("R8 no refresh", n_ref, r0);
        release_all();
        chk("R8 test latched", test_mode, 1);
    endtask

    initial begin
        int a0, r0, w0, f0;
        logic [3:0] p;
        logic [1:0] exp_dq;
        logic [COL_W-1:0] c;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        settle();
        chk("R1 reset code", cyc_code, 0);
        chk("R1 reset test", test_mode, 0);
        chk("R1 reset oe", dq_oe, 0);

        // Normal reads over every row
        for (int r = 0; r < 16; r++) begin
            a0 = n_act; r0 = n_rd; f0 = n_ref;
            c = COL_W'(r);
            p = 4'((r * 5 + 3) & 15);
            array_rd = p;
            row_in = ROW_W'(r);
            ras_n = 1'b0; settle();
            chk("R2 row open code", cyc_code, 7);
            chk("R2 row latched", row_addr, r);
            chk("R2 act pulse", n_act, a0 + 1);
            col_in = c; oe_n = 1'b0; cas_n = 1'b0; settle();
            chk("R3 read code", cyc_code, 1);
            chk("R3 col latched", col_addr, c);
            chk("R3 rd pulse", n_rd, r0 + 1);
            chk("R9 oe in read", dq_oe, 1);
            exp_dq = c[COL_W-1] ? p[3:2] : p[1:0];
            chk("R10 normal data", dq_out, exp_dq);
            cas_n = 1'b1; settle();
            chk("R9 oe off cas high", dq_oe, 0);
            oe_n = 1'b1; ras_n = 1'b1; settle();
            chk("R6 no refresh after read", n_ref, f0);
            chk("R3 code kept", cyc_code, 1);
        end

        // Page mode: second column in same row
        r0 = n_rd;
        row_in = 4'd2; ras_n = 1'b0; settle();
        col_in = 4'd1; cas_n = 1'b0; settle();
        cas_n = 1'b1; settle();
        col_in = 4'd12; cas_n = 1'b0; settle();
        chk("R3 page second col", col_addr, 12);
        chk("R3 page two reads", n_rd, r0 + 2);
        release_all();

        // Early write
        w0 = n_wr;
        row_in = 4'd5; ras_n = 1'b0; settle();
        we_n = 1'b0; oe_n = 1'b0; cas_n = 1'b0; settle();
        chk("R4 early write code", cyc_code, 2);
        chk("R4 wr pulse", n_wr, w0 + 1);
        chk("R4 oe stays off", dq_oe, 0);
        release_all();

        // Read-modify-write
        w0 = n_wr;
        row_in = 4'd9; ras_n = 1'b0; settle();
        oe_n = 1'b0; cas_n = 1'b0; settle();
        chk("R5 read first", cyc_code, 1);
        chk("R9 rmw read phase oe", dq_oe, 1);
        oe_n = 1'b1; we_n = 1'b0; settle();
        chk("R5 rmw code", cyc_code, 3);
        chk("R5 wr pulse", n_wr, w0 + 1);
        release_all();

        // Row-only refresh
        for (int r = 0; r < 4; r++) begin
            f0 = n_ref;
            row_in = ROW_W'(r * 3 + 1);
            ras_n = 1'b0; settle();
            ras_n = 1'b1; settle();
            chk("R6 ror code", cyc_code, 4);
            chk("R6 ror pulse", n_ref, f0 + 1);
            chk("R6 ror row", last_ref_row, r * 3 + 1);
        end

        // Column-before-row refresh across counter wrap
        for (int i = 0; i < 18; i++) cbr_cycle(i % 16, 5);

        // Hidden refresh: counter now at 2
        row_in = 4'd3; col_in = 4'd1;
        ras_n = 1'b0; settle();
        oe_n = 1'b0; cas_n = 1'b0; settle();
        chk("R3 hidden read", cyc_code, 1);
        ras_n = 1'b1; settle();
        f0 = n_ref;
        ras_n = 1'b0; settle();
        chk("R7 hidden code", cyc_code, 5);
        chk("R7 hidden row", last_ref_row, 2);
        chk("R7 hidden pulse", n_ref, f0 + 1);
        chk("R9 hidden oe off", dq_oe, 0);
        release_all();

        // Simultaneous row and column fall counts as row first
        a0 = n_act; f0 = n_ref;
        row_in = 4'd6;
        ras_n = 1'b0; cas_n = 1'b0; settle();
        chk("R2 simultaneous code", cyc_code, 1);
        chk("R2 simultaneous act", n_act, a0 + 1);
        chk("R2 simultaneous row", row_addr, 6);
        chk("R2 simultaneous no ref", n_ref, f0);
        release_all();

        // Test mode compression sweep
        enter_test();
        for (int v = 0; v < 16; v++) begin
            for (int m = 0; m < 2; m++) begin
                p = 4'(v);
                array_rd = p;
                row_in = 4'(v);
                ras_n = 1'b0; settle();
                col_in = {1'(m), 3'(v)};
                oe_n = 1'b0; cas_n = 1'b0; settle();
                exp_dq = ~(p[1:0] ^ p[3:2]);
                chk("R10 test compare", dq_out, exp_dq);
                chk("R8 test held", test_mode, 1);
                release_all();
            end
        end

        // Row-only refresh leaves test mode
        ras_n = 1'b0; settle();
        ras_n = 1'b1; settle();
        chk("R6 ror clears test", test_mode, 0);

        // Column-before-row refresh leaves test mode (counter at 3)
        enter_test();
        cbr_cycle(3, 5);
        chk("R7 cbr clears test", test_mode, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule